// File: doc/BRIEF.md
# Ping-Pong DMA Channel Engine

This block is one DMA channel. It moves fixed-size units between a peripheral that uses a request/acknowledge handshake and a memory master port that also uses request/acknowledge. The channel keeps two buffer descriptors, pair A and pair B. Each pair holds a current address and an end word. The engine drains one pair while software refills the other, and it moves from one pair to the next with no extra cycle.

Software sees six registers on a simple write/read register bus: the two current addresses, the two end words, a control byte and a status byte. The status byte raises an interrupt while either pair is empty and names the pair that software should fill next. It also reports an overflow when the engine ran out of loaded pairs. Two flags in the upper bits of each end word control how a transfer sequence ends. A stop flag halts the channel after that pair completes. Both flags together with a zero end address form a terminator that halts the channel at once, with no transfer.

The engine state machine has three states:
- IDLE: waits for enable, a loaded active pair and a device request.
  - IDLE→XFER: a device request arrives while the channel is enabled and the active pair is loaded.
  - IDLE→HALT: the active pair is a terminator.
- XFER: holds the memory request until it is acknowledged.
  - XFER→IDLE: an access completes, unless the stop flag ends the chain.
  - XFER→HALT: the pair that just completed carries the stop flag.
- HALT: stays until a clear.

A clear returns every state to IDLE with pair A active.

Top module: `pingpong_dma`

## Requirements
- R1: After reset, all six registers read zero, `irq` is low and `mem_req` is low.
- R2: Register offsets on `reg_addr`:
  - 0 is current-A, 1 is end-A, 2 is current-B, 3 is end-B, 4 is control and 5 is status.
  - Current and end registers read back what was written. The current register holds only its low ADDR_W bits.
  - In an end word, bit 31 is the stop flag, bit 30 is the last flag and the low ADDR_W bits are the end address. The bits between them are stored and read back with no effect.
- R3: While enabled with the active pair loaded, a high `dev_req` starts an access. `mem_req` is held with `mem_addr` equal to the active current address.
  - Control bit 5 set means device-to-memory: `mem_we`=1 and `mem_wdata`=`dev_din`.
  - `dev_ack` pulses in the cycle the access is acknowledged.
  - For memory-to-device, `dev_dout` takes `mem_rdata` at that point.
- R4: The control size field, bits 1:0, sets the address step: 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes and 0 gives 16 bytes.
- R5: Each acknowledged access advances the active current address by the step. A pair completes after the access whose address was at or past its end address. On completion the other pair becomes active, and if it is loaded its first access follows with the same spacing as accesses within one pair.
- R6: If a pair completes while the other pair is empty, status bit 6 (overflow) sets and no access is issued. Loading the now-active pair clears overflow and resumes transfers.
- R7: `irq` and status bit 7 are high when control bit 7 (enable) is set, the channel is not halted, and at least one pair is empty. Status bit 0 names the pair to program next (0=A, 1=B): the active pair if it is empty, otherwise the other pair.
- R8: Writing an end register marks its pair loaded. Writing only a current register does not.
- R9: When a pair whose end word has the stop flag completes, the channel halts. No access follows even if the other pair is loaded, and `irq` stays low.
- R10: An active pair whose end word has both flags set and a zero end address halts the channel with no access.
- R11: Clearing the enable bit while `mem_req` is pending keeps the request until it is acknowledged. No new access starts afterwards.
- R12: A control write with bit 6 (clear) set resets the channel:
  - both pairs become empty and their registers zero;
  - pair A becomes active;
  - overflow and halt are cleared.
  
  The other control bits of that write are stored. Bit 6 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Peripheral unit accepted/delivered |
| dev_din | input | DW | Data from peripheral |
| dev_dout | output | DW | Data to peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory access acknowledge |

## Verification
A corrupted active-pair selector shows on `mem_addr` at the very next request, because the address comes from the wrong pair's current register. A wrong loaded flag shows in the status byte and on `irq` in the cycle after the offending write. It also appears as a missing or extra access on the next device request. A wrong completion compare or step appears as a mis-spaced or missing address in the transfer sequence within one pair. A broken switch shows as a gap in cycle spacing at the A-to-B boundary or as a false overflow.

// File: rtl/ppdma_pkg.sv
`timescale 1ns/1ps
package ppdma_pkg;
    localparam int RW       = 32;
    localparam int STOP_BIT = 31;
    localparam int LAST_BIT = 30;

    localparam logic [2:0] OFS_CUR_A = 3'd0;
    localparam logic [2:0] OFS_END_A = 3'd1;
    localparam logic [2:0] OFS_CUR_B = 3'd2;
    localparam logic [2:0] OFS_END_B = 3'd3;
    localparam logic [2:0] OFS_CTRL  = 3'd4;
    localparam logic [2:0] OFS_STAT  = 3'd5;

    localparam int CTL_EN  = 7;
    localparam int CTL_CLR = 6;
    localparam int CTL_DIR = 5;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_XFER = 2'd1,
        ENG_HALT = 2'd2
    } eng_state_e;

    function automatic logic [4:0] step_bytes(input logic [1:0] code);
        logic [4:0] s;
        unique case (code)
            2'd1:    s = 5'd1;
            2'd2:    s = 5'd2;
            2'd3:    s = 5'd4;
            default: s = 5'd16;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/ppdma_pair.sv
`timescale 1ns/1ps
module ppdma_pair
    import ppdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_cur,
    input  logic          wr_end,
    input  logic [RW-1:0] wdata,
    input  logic          adv,
    input  logic [4:0]    step,
    input  logic          retire,
    output logic [AW-1:0] cur,
    output logic [RW-1:0] end_word,
    output logic          loaded
);
    localparam int PADW = AW - 5;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= '0;
            end_word <= '0;
            loaded   <= 1'b0;
        end else if (clr) begin
            cur      <= '0;
            end_word <= '0;
            loaded   <= 1'b0;
        end else begin
            if (wr_cur)
                cur <= wdata[AW-1:0];
            else if (adv)
                cur <= cur + {{PADW{1'b0}}, step};
            if (wr_end) begin
                end_word <= wdata;
                loaded   <= 1'b1;
            end else if (retire) begin
                loaded   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ppdma_engine.sv
`timescale 1ns/1ps
module ppdma_engine
    import ppdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [1:0]          loaded,
    input  logic [1:0][AW-1:0]  cur,
    input  logic [1:0][AW-1:0]  end_addr,
    input  logic [1:0]          stop,
    input  logic [1:0]          last,
    input  logic                dev_req,
    input  logic                mem_ack,
    output logic                mem_req,
    output logic [AW-1:0]       mem_addr,
    output logic [1:0]          adv,
    output logic [1:0]          retire,
    output logic                act,
    output logic                complete,
    output logic                halted,
    output logic                dev_ack
);
    eng_state_e st, st_nxt;

    logic          a_loaded, a_stop, a_last, a_term, a_fin;
    logic [AW-1:0] a_cur, a_end;
    logic          fire, kill;

    assign a_loaded = loaded[act];
    assign a_cur    = cur[act];
    assign a_end    = end_addr[act];
    assign a_stop   = stop[act];
    assign a_last   = last[act];
    assign a_term   = a_stop && a_last && (a_end == '0);
    assign a_fin    = (a_cur >= a_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ENG_IDLE;
            act <= 1'b0;
        end else if (clr) begin
            st  <= ENG_IDLE;
            act <= 1'b0;
        end else begin
            st <= st_nxt;
            if (complete)
                act <= ~act;
        end
    end

    always_comb begin
        st_nxt   = st;
        mem_req  = 1'b0;
        fire     = 1'b0;
        kill     = 1'b0;
        complete = 1'b0;
        unique case (st)
            ENG_IDLE: begin
                if (en && a_loaded) begin
                    if (a_term) begin
                        kill   = 1'b1;
                        st_nxt = ENG_HALT;
                    end else if (dev_req) begin
                        st_nxt = ENG_XFER;
                    end
                end
            end
            ENG_XFER: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fire = 1'b1;
                    if (a_fin) begin
                        complete = 1'b1;
                        st_nxt   = a_stop ? ENG_HALT : ENG_IDLE;
                    end else begin
                        st_nxt   = ENG_IDLE;
                    end
                end
            end
            ENG_HALT: st_nxt = ENG_HALT;
            default:  st_nxt = ENG_IDLE;
        endcase
    end

    always_comb begin
        adv       = 2'b00;
        retire    = 2'b00;
        adv[act]    = fire;
        retire[act] = complete || kill;
    end

    assign mem_addr = a_cur;
    assign halted   = (st == ENG_HALT);
    assign dev_ack  = fire;
endmodule

// File: rtl/pingpong_dma.sv
`timescale 1ns/1ps
module pingpong_dma
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    output logic              irq,
    input  logic              dev_req,
    output logic              dev_ack,
    input  logic [DW-1:0]     dev_din,
    output logic [DW-1:0]     dev_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack
);
    localparam int NPAIR = 2;

    logic [7:0]                   ctrl_q;
    logic                         ovf_q;
    logic [DW-1:0]                dout_q;
    logic                         clr;
    logic [4:0]                   step;
    logic [NPAIR-1:0]             loaded_v, stop_v, last_v, adv_v, retire_v;
    logic [NPAIR-1:0][ADDR_W-1:0] cur_v, end_v;
    logic [NPAIR-1:0][RW-1:0]     endw_v;
    logic                         act, complete, halted, fire;
    logic                         nxt_sel;

    assign clr  = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CTL_CLR];
    assign step = step_bytes(ctrl_q[1:0]);

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        ppdma_pair #(.AW(ADDR_W)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .wr_cur   (reg_wr && (reg_addr == 3'(2*g))),
            .wr_end   (reg_wr && (reg_addr == 3'(2*g+1))),
            .wdata    (reg_wdata),
            .adv      (adv_v[g]),
            .step     (step),
            .retire   (retire_v[g]),
            .cur      (cur_v[g]),
            .end_word (endw_v[g]),
            .loaded   (loaded_v[g])
        );
        assign end_v[g]  = endw_v[g][ADDR_W-1:0];
        assign stop_v[g] = endw_v[g][STOP_BIT];
        assign last_v[g] = endw_v[g][LAST_BIT];
    end

    ppdma_engine #(.AW(ADDR_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .en       (ctrl_q[CTL_EN]),
        .loaded   (loaded_v),
        .cur      (cur_v),
        .end_addr (end_v),
        .stop     (stop_v),
        .last     (last_v),
        .dev_req  (dev_req),
        .mem_ack  (mem_ack),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .adv      (adv_v),
        .retire   (retire_v),
        .act      (act),
        .complete (complete),
        .halted   (halted),
        .dev_ack  (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && (reg_addr == OFS_CTRL)) begin
            ctrl_q          <= reg_wdata[7:0];
            ctrl_q[CTL_CLR] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (clr)
            ovf_q <= 1'b0;
        else if (complete && !loaded_v[~act])
            ovf_q <= 1'b1;
        else if (ovf_q && loaded_v[act])
            ovf_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout_q <= '0;
        else if (fire && !ctrl_q[CTL_DIR])
            dout_q <= mem_rdata;
    end

    assign nxt_sel   = loaded_v[act] ? ~act : act;
    assign irq       = ctrl_q[CTL_EN] && !halted && !(&loaded_v);
    assign dev_ack   = fire;
    assign dev_dout  = dout_q;
    assign mem_we    = ctrl_q[CTL_DIR];
    assign mem_wdata = dev_din;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CUR_A: reg_rdata[ADDR_W-1:0] = cur_v[0];
            OFS_END_A: reg_rdata = endw_v[0];
            OFS_CUR_B: reg_rdata[ADDR_W-1:0] = cur_v[1];
            OFS_END_B: reg_rdata = endw_v[1];
            OFS_CTRL:  reg_rdata[7:0] = ctrl_q;
            OFS_STAT:  reg_rdata[7:0] = {irq, ovf_q, 5'b0, nxt_sel};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppdma_chk.sv
`timescale 1ns/1ps
module ppdma_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          dev_ack,
    input logic          ovf,
    input logic          halted,
    input logic          irq,
    input logic          loaded_a
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr)));

    // R3
    ack_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |-> dev_ack);

    // R6
    ovf_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !mem_req);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !irq));

    // R8
    load_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> loaded_a);
endmodule

bind pingpong_dma ppdma_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .dev_ack  (dev_ack),
    .ovf      (ovf_q),
    .halted   (halted),
    .irq      (irq),
    .loaded_a (loaded_v[0])
);

// File: tb/pingpong_dma_tb.sv
`timescale 1ns/1ps
module pingpong_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        dev_req = 1'b0;
    logic        dev_ack;
    logic [15:0] dev_din = 16'h5AC3;
    logic [15:0] dev_dout;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        ack_en = 1'b1;

    integer n_chk = 0, n_fail = 0, n_x = 0, cyc = 0, n_ack = 0;
    logic [15:0] xa [64];
    logic        xw [64];
    logic [15:0] xd [64];
    integer      xc [64];
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    pingpong_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dev_req(dev_req), .dev_ack(dev_ack), .dev_din(dev_din), .dev_dout(dev_dout),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign mem_rdata = ~mem_addr;

    always @(posedge clk) mem_ack <= mem_req && !mem_ack && ack_en;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (dev_ack) n_ack = n_ack + 1;
        if (mem_req && mem_ack && n_x < 64) begin
            xa[n_x] = mem_addr; xw[n_x] = mem_we; xd[n_x] = mem_wdata; xc[n_x] = cyc;
            n_x = n_x + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  code;
        logic        dir;
        logic [15:0] start;
        logic [15:0] stop;
        logic [7:0]  cnt;
        logic [4:0]  stride;
    } vec_t;

    // step-size table (R4, R5, R3)
    localparam vec_t VECS [6] = '{
        '{2'd1, 1'b1, 16'h0100, 16'h0103, 8'd4, 5'd1},
        '{2'd2, 1'b0, 16'h0200, 16'h0206, 8'd4, 5'd2},
        '{2'd3, 1'b1, 16'h0300, 16'h030C, 8'd4, 5'd4},
        '{2'd0, 1'b0, 16'h0400, 16'h0430, 8'd4, 5'd16},
        '{2'd2, 1'b1, 16'h0500, 16'h0500, 8'd1, 5'd2},
        '{2'd2, 1'b1, 16'h0600, 16'h0601, 8'd2, 5'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic run(input integer n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh();
        wr(3'd4, 32'h40);
        n_x = 0; n_ack = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail = n_fail + 1; n_chk = n_chk + 1;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(2);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), rv);
            chk($sformatf("R1 reg %0d", a), rv, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);

        // R2 register map readback
        wr(3'd0, 32'hFFFF_1234); rd(3'd0, rv); chk("R2 curA", rv, 32'h0000_1234);
        wr(3'd1, 32'hC000_5678); rd(3'd1, rv); chk("R2 endA", rv, 32'hC000_5678);
        wr(3'd2, 32'h0000_4321); rd(3'd2, rv); chk("R2 curB", rv, 32'h0000_4321);
        wr(3'd3, 32'h3FFF_0010); rd(3'd3, rv); chk("R2 endB", rv, 32'h3FFF_0010);
        wr(3'd4, 32'h0000_0023); rd(3'd4, rv); chk("R2 ctrl", rv, 32'h23);

        // R12 clear resets channel, stores other bits, clear bit reads zero
        wr(3'd4, 32'h0000_0043);
        rd(3'd4, rv); chk("R12 ctrl after clear", rv, 32'h03);
        rd(3'd1, rv); chk("R12 endA zeroed", rv, 32'h0);
        rd(3'd5, rv); chk("R12 status", rv, 32'h0);

        // vector table walk: R3 R4 R5 R9
        for (int v = 0; v < 6; v++) begin
            fresh();
            wr(3'd0, {16'h0, VECS[v].start});
            wr(3'd1, {16'h8000, VECS[v].stop});
            wr(3'd4, {24'h0, 1'b1, 1'b0, VECS[v].dir, 3'b0, VECS[v].code});
            dev_req = 1'b1;
            run(60);
            dev_req = 1'b0;
            chk($sformatf("R5 count vec%0d", v), n_x, 32'(VECS[v].cnt));
            for (int i = 0; i < int'(VECS[v].cnt); i++)
                chk($sformatf("R4 addr vec%0d #%0d", v, i), {16'h0, xa[i]},
                    {16'h0, VECS[v].start + 16'(i * int'(VECS[v].stride))});
            chk($sformatf("R3 we vec%0d", v), {31'b0, xw[0]}, {31'b0, VECS[v].dir});
            chk($sformatf("R3 dev_ack count vec%0d", v), n_ack, 32'(VECS[v].cnt));
            if (VECS[v].dir) chk($sformatf("R3 wdata vec%0d", v), {16'h0, xd[0]}, {16'h0, dev_din});
            chk($sformatf("R9 irq low vec%0d", v), {31'b0, irq}, 32'h0);
        end

        // R7 R8 status and irq while loading
        fresh();
        wr(3'd4, 32'h82);
        rd(3'd5, rv); chk("R7 both empty", rv, 32'h80);
        chk("R7 irq pin", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h1000);
        rd(3'd5, rv); chk("R8 cur only not loaded", rv, 32'h80);
        wr(3'd1, 32'h1002);
        rd(3'd5, rv); chk("R8 end loads A", rv, 32'h81);
        wr(3'd2, 32'h2000);
        wr(3'd3, 32'h2004);
        rd(3'd5, rv); chk("R7 both loaded", rv, 32'h01);
        chk("R7 irq pin low", {31'b0, irq}, 32'h0);

        // R5 R6 ping-pong then overflow
        dev_req = 1'b1;
        run(60);
        chk("R5 pingpong count", n_x, 5);
        chk("R5 first B addr", {16'h0, xa[2]}, 32'h2000);
        chk("R5 no gap at switch", xc[2] - xc[1], xc[1] - xc[0]);
        rd(3'd5, rv); chk("R6 overflow status", rv, 32'hC0);
        chk("R6 stalled", {31'b0, mem_req}, 32'h0);
        wr(3'd0, 32'h3000);
        wr(3'd1, 32'h3000);
        run(20);
        chk("R6 resumed count", n_x, 6);
        chk("R6 resumed addr", {16'h0, xa[5]}, 32'h3000);
        chk("R3 dev_dout", {16'h0, dev_dout}, {16'h0, ~16'h3000});
        rd(3'd5, rv); chk("R6 overflow again", rv, 32'hC1);
        dev_req = 1'b0;

        // R9 stop flag halts despite loaded B
        fresh();
        wr(3'd0, 32'h0100); wr(3'd1, 32'h8000_0102);
        wr(3'd2, 32'h0200); wr(3'd3, 32'h0000_0200);
        wr(3'd4, 32'h82);
        dev_req = 1'b1; run(40); dev_req = 1'b0;
        chk("R9 stop count", n_x, 2);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        rd(3'd5, rv); chk("R9 status", rv, 32'h00);

        // R10 terminator
        fresh();
        wr(3'd0, 32'h0500); wr(3'd1, 32'hC000_0000);
        wr(3'd2, 32'h0600); wr(3'd3, 32'h0000_0600);
        wr(3'd4, 32'h82);
        dev_req = 1'b1; run(30); dev_req = 1'b0;
        chk("R10 no transfer", n_x, 0);
        chk("R10 irq", {31'b0, irq}, 32'h0);

        // R11 disable with request in flight
        fresh();
        ack_en = 1'b0;
        wr(3'd0, 32'h0700); wr(3'd1, 32'h0000_070E);
        wr(3'd4, 32'h82);
        dev_req = 1'b1; run(3);
        chk("R11 pending", {31'b0, mem_req}, 32'h1);
        wr(3'd4, 32'h02);
        chk("R11 held after disable", {31'b0, mem_req}, 32'h1);
        ack_en = 1'b1;
        run(20);
        chk("R11 one transfer", n_x, 1);
        chk("R11 no new req", {31'b0, mem_req}, 32'h0);
        dev_req = 1'b0;

        // R12 clear after activity
        wr(3'd4, 32'h40);
        rd(3'd0, rv); chk("R12 curA zero", rv, 32'h0);
        rd(3'd5, rv); chk("R12 status zero", rv, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule